// File: doc/BRIEF.md
# Conditional Return and Call Stack Unit

This unit is the program-flow part of a small processor core. It owns the 16-bit instruction pointer and a hardware stack of return addresses. Each cycle the decoder may present one of three instructions: a plain sequential step, a call, or a return. A call saves the address of the instruction after it on the stack and jumps to its target. A return can be unconditional, or it can depend on the carry flag, the sign flag, or a zero flag that the unit derives from the 8-bit accumulator.

A guarded return whose condition holds pops the top entry and resumes there. A guarded return whose condition fails acts like an ordinary instruction. The pointer moves to the next address and the stack is left as it was. The stack holds sixteen entries and reports its depth and its full and empty states. A call that finds the stack full, or a taken return that finds it empty, raises a one-cycle fault flag and leaves the stored addresses as they were.

Top module: `retstk_unit`

## Requirements
- R1: While reset is high, on every clock edge the instruction pointer goes to 0000h, the depth goes to 0, `stack_empty` goes to 1, and both fault flags go to 0.
- R2: `step_req` alone advances the pointer by one. A cycle with no request holds the pointer and the stack.
- R3: A call to a non-full stack pushes the pointer plus one, loads `call_target` into the pointer, and raises the depth by one.
- R4: `ret_cond` selects the guard: 0 = carry is 1, 1 = carry is 0, 4 = sign is 1. A taken return loads the pointer from the newest entry and lowers the depth by one.
- R5: Codes 2 (zero) and 3 (not zero) are judged on the zero flag. The zero flag is 1 exactly when `acc_in` equals 00h.
- R6: A return whose guard fails leaves the depth and the stored entries unchanged and advances the pointer by one.
- R7: Code 7 is an unconditional return. Codes 5 and 6 are never taken.
- R8: Entries come back in last-in, first-out order, up to 16 deep. `stack_full` is 1 at depth 16 and `stack_empty` is 1 at depth 0.
- R9: A call at depth 16 pushes nothing and advances the pointer by one. It sets `overflow_flag` for exactly the following cycle, and all stored entries stay as they were.
- R10: A taken return at depth 0 advances the pointer by one, keeps the depth at 0, and sets `underflow_flag` for exactly the following cycle.
- R11: When a call and a return are requested in the same cycle, the call is executed and the return is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_req | input | 1 | Sequential instruction executed |
| call_req | input | 1 | Call instruction executed |
| call_target | input | 16 | Destination of the call |
| ret_req | input | 1 | Return instruction executed |
| ret_cond | input | 3 | Return guard code |
| carry_in | input | 1 | Carry status flag |
| sign_in | input | 1 | Sign status flag |
| acc_in | input | 8 | Accumulator value |
| ip_out | output | 16 | Instruction pointer |
| stack_depth | output | 5 | Number of stored return addresses |
| stack_full | output | 1 | Depth equals 16 |
| stack_empty | output | 1 | Depth equals 0 |
| overflow_flag | output | 1 | Previous cycle's call found the stack full |
| underflow_flag | output | 1 | Previous cycle's taken return found the stack empty |

## Verification
A call and a return can both arrive in one cycle. The stack would then have to push and pop together, and the pointer would have two possible sources. The bench provokes this by asserting `call_req` and an always-taken `ret_req` together after one earlier call. It then expects the call's target in the pointer and a depth one higher. Two plain returns follow, and their popped addresses are checked to show that the discarded return removed no entry.

// File: rtl/retstk_pkg.sv
package retstk_pkg;

    localparam int ADDR_W    = 16;
    localparam int STK_DEPTH = 16;
    localparam int ACC_W     = 8;

    typedef enum logic [2:0] {
        CC_CARRY  = 3'd0,
        CC_NCARRY = 3'd1,
        CC_ZERO   = 3'd2,
        CC_NZERO  = 3'd3,
        CC_SIGN   = 3'd4,
        CC_RSV5   = 3'd5,
        CC_RSV6   = 3'd6,
        CC_ALWAYS = 3'd7
    } cond_e;

    typedef struct packed {
        logic carry;
        logic sign;
        logic zero;
    } flags_t;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_SEQ  = 2'd1,
        ACT_JUMP = 2'd2,
        ACT_POP  = 2'd3
    } ip_act_e;

    typedef struct packed {
        ip_act_e act;
        logic    push;
        logic    pop;
        logic    ovf_ev;
        logic    unf_ev;
    } plan_t;

    function automatic logic cond_true(input cond_e c, input flags_t f);
        logic r;
        case (c)
            CC_CARRY:  r = f.carry;
            CC_NCARRY: r = !f.carry;
            CC_ZERO:   r = f.zero;
            CC_NZERO:  r = !f.zero;
            CC_SIGN:   r = f.sign;
            CC_ALWAYS: r = 1'b1;
            default:   r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/retstk_cond.sv
module retstk_cond
    import retstk_pkg::*;
#(
    parameter int AW_ACC = ACC_W
) (
    input  logic [2:0]        cond_code,
    input  logic              carry,
    input  logic              sign,
    input  logic [AW_ACC-1:0] acc,
    output logic              ok
);
    flags_t flags;

    always_comb begin
        flags.carry = carry;
        flags.sign  = sign;
        flags.zero  = (acc == '0);
        ok          = cond_true(cond_e'(cond_code), flags);
    end

endmodule

// File: rtl/retstk_ctrl.sv
module retstk_ctrl
    import retstk_pkg::*;
(
    input  logic  step_req,
    input  logic  call_req,
    input  logic  ret_req,
    input  logic  cond_ok,
    input  logic  full,
    input  logic  empty,
    output plan_t plan
);
    always_comb begin
        plan        = '0;
        plan.act    = ACT_HOLD;
        if (call_req) begin
            if (!full) begin
                plan.push = 1'b1;
                plan.act  = ACT_JUMP;
            end else begin
                plan.ovf_ev = 1'b1;
                plan.act    = ACT_SEQ;
            end
        end else if (ret_req) begin
            if (cond_ok && !empty) begin
                plan.pop = 1'b1;
                plan.act = ACT_POP;
            end else begin
                plan.unf_ev = cond_ok;
                plan.act    = ACT_SEQ;
            end
        end else if (step_req) begin
            plan.act = ACT_SEQ;
        end
    end

endmodule

// File: rtl/retstk_lifo.sv
module retstk_lifo #(
    parameter int DW    = 16,
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    input  logic [DW-1:0]    push_data,
    output logic [DW-1:0]    top_data,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);
    logic [DW-1:0]    mem [DEPTH];
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] top_pos;

    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign count   = cnt_q;
    assign top_pos = cnt_q - 1'b1;
    assign top_data = empty ? '0 : mem[top_pos[IDX_W-1:0]];

    always_ff @(posedge clk) begin
        if (push && !full) begin
            mem[cnt_q[IDX_W-1:0]] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (push && !full) begin
            cnt_q <= cnt_q + 1'b1;
        end else if (pop && !empty) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    p_depth_bound_r8: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(DEPTH));

    p_push_grows_r3: assert property (@(posedge clk) disable iff (rst)
        (push && !full) |=> (cnt_q == $past(cnt_q) + 1'b1));

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
        (push && full) |=> (cnt_q == CNT_W'(DEPTH)));

    p_no_underflow_r10: assert property (@(posedge clk) disable iff (rst)
        (pop && !push && empty) |=> (cnt_q == '0));

endmodule

// File: rtl/retstk_unit.sv
module retstk_unit
    import retstk_pkg::*;
#(
    parameter int AW    = ADDR_W,
    parameter int DEPTH = STK_DEPTH,
    parameter int XW    = ACC_W,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_req,
    input  logic             call_req,
    input  logic [AW-1:0]    call_target,
    input  logic             ret_req,
    input  logic [2:0]       ret_cond,
    input  logic             carry_in,
    input  logic             sign_in,
    input  logic [XW-1:0]    acc_in,
    output logic [AW-1:0]    ip_out,
    output logic [CNT_W-1:0] stack_depth,
    output logic             stack_full,
    output logic             stack_empty,
    output logic             overflow_flag,
    output logic             underflow_flag
);
    logic [AW-1:0] ip_q;
    logic [AW-1:0] ip_d;
    logic [AW-1:0] ip_inc;
    logic [AW-1:0] top_addr;
    logic          cond_ok;
    logic          ovf_q;
    logic          unf_q;
    plan_t         plan;

    assign ip_inc = ip_q + 1'b1;

    retstk_cond #(.AW_ACC(XW)) u_cond (
        .cond_code (ret_cond),
        .carry     (carry_in),
        .sign      (sign_in),
        .acc       (acc_in),
        .ok        (cond_ok)
    );

    retstk_ctrl u_ctrl (
        .step_req (step_req),
        .call_req (call_req),
        .ret_req  (ret_req),
        .cond_ok  (cond_ok),
        .full     (stack_full),
        .empty    (stack_empty),
        .plan     (plan)
    );

    retstk_lifo #(.DW(AW), .DEPTH(DEPTH)) u_lifo (
        .clk       (clk),
        .rst       (rst),
        .push      (plan.push),
        .pop       (plan.pop),
        .push_data (ip_inc),
        .top_data  (top_addr),
        .count     (stack_depth),
        .full      (stack_full),
        .empty     (stack_empty)
    );

    always_comb begin
        case (plan.act)
            ACT_SEQ:  ip_d = ip_inc;
            ACT_JUMP: ip_d = call_target;
            ACT_POP:  ip_d = top_addr;
            default:  ip_d = ip_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ip_q  <= '0;
            ovf_q <= 1'b0;
            unf_q <= 1'b0;
        end else begin
            ip_q  <= ip_d;
            ovf_q <= plan.ovf_ev;
            unf_q <= plan.unf_ev;
        end
    end

    assign ip_out         = ip_q;
    assign overflow_flag  = ovf_q;
    assign underflow_flag = unf_q;

    p_fail_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (ret_req && !call_req && !cond_ok)
        |=> ($stable(stack_depth) && ip_q == AW'($past(ip_q) + 1'b1)));

    p_ret_pops_r4: assert property (@(posedge clk) disable iff (rst)
        (ret_req && !call_req && cond_ok && !stack_empty)
        |=> (stack_depth == $past(stack_depth) - 1'b1));

    p_call_wins_r11: assert property (@(posedge clk) disable iff (rst)
        (call_req && ret_req && !stack_full)
        |=> (ip_q == $past(call_target)));

    p_ovf_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        (call_req && stack_full) |=> (overflow_flag && !underflow_flag));

    p_flags_excl_r10: assert property (@(posedge clk) disable iff (rst)
        !(overflow_flag && underflow_flag));

endmodule

// File: tb/retstk_unit_test.sv
module retstk_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        step_req = 1'b0;
    logic        call_req = 1'b0;
    logic [15:0] call_target = '0;
    logic        ret_req = 1'b0;
    logic [2:0]  ret_cond = '0;
    logic        carry_in = 1'b0;
    logic        sign_in = 1'b0;
    logic [7:0]  acc_in = '0;
    logic [15:0] ip_out;
    logic [4:0]  stack_depth;
    logic        stack_full;
    logic        stack_empty;
    logic        overflow_flag;
    logic        underflow_flag;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #5 clk = ~clk;

    retstk_unit uut (
        .clk            (clk),
        .rst            (rst),
        .step_req       (step_req),
        .call_req       (call_req),
        .call_target    (call_target),
        .ret_req        (ret_req),
        .ret_cond       (ret_cond),
        .carry_in       (carry_in),
        .sign_in        (sign_in),
        .acc_in         (acc_in),
        .ip_out         (ip_out),
        .stack_depth    (stack_depth),
        .stack_full     (stack_full),
        .stack_empty    (stack_empty),
        .overflow_flag  (overflow_flag),
        .underflow_flag (underflow_flag)
    );

    // row: {step, call, target, ret, cond, carry, sign, acc, exp_ip, exp_depth}
    localparam int NV = 21;
    localparam logic [52:0] TBL [NV] = '{
        {1'b1,1'b0,16'h0000,1'b0,3'd0,1'b0,1'b0,8'h00,16'h0001,5'd0},
        {1'b0,1'b1,16'h0100,1'b0,3'd0,1'b0,1'b0,8'h00,16'h0100,5'd1},
        {1'b1,1'b0,16'h0000,1'b0,3'd0,1'b0,1'b0,8'h00,16'h0101,5'd1},
        {1'b0,1'b1,16'h0200,1'b0,3'd0,1'b0,1'b0,8'h00,16'h0200,5'd2},
        {1'b0,1'b0,16'h0000,1'b1,3'd0,1'b0,1'b0,8'h00,16'h0201,5'd2},
        {1'b0,1'b0,16'h0000,1'b1,3'd0,1'b1,1'b0,8'h00,16'h0102,5'd1},
        {1'b0,1'b1,16'h0300,1'b0,3'd0,1'b0,1'b0,8'h00,16'h0300,5'd2},
        {1'b0,1'b0,16'h0000,1'b1,3'd2,1'b0,1'b0,8'h05,16'h0301,5'd2},
        {1'b0,1'b0,16'h0000,1'b1,3'd3,1'b0,1'b0,8'h05,16'h0103,5'd1},
        {1'b0,1'b1,16'h0400,1'b0,3'd0,1'b0,1'b0,8'h00,16'h0400,5'd2},
        {1'b0,1'b0,16'h0000,1'b1,3'd1,1'b1,1'b0,8'h00,16'h0401,5'd2},
        {1'b0,1'b0,16'h0000,1'b1,3'd1,1'b0,1'b0,8'h00,16'h0104,5'd1},
        {1'b0,1'b1,16'h0500,1'b0,3'd0,1'b0,1'b0,8'h00,16'h0500,5'd2},
        {1'b0,1'b0,16'h0000,1'b1,3'd4,1'b0,1'b0,8'h00,16'h0501,5'd2},
        {1'b0,1'b0,16'h0000,1'b1,3'd4,1'b0,1'b1,8'h00,16'h0105,5'd1},
        {1'b0,1'b1,16'h0600,1'b0,3'd0,1'b0,1'b0,8'h00,16'h0600,5'd2},
        {1'b0,1'b0,16'h0000,1'b1,3'd3,1'b0,1'b0,8'h00,16'h0601,5'd2},
        {1'b0,1'b0,16'h0000,1'b1,3'd2,1'b0,1'b0,8'h00,16'h0106,5'd1},
        {1'b0,1'b0,16'h0000,1'b1,3'd5,1'b1,1'b1,8'h00,16'h0107,5'd1},
        {1'b0,1'b0,16'h0000,1'b1,3'd7,1'b0,1'b0,8'h00,16'h0002,5'd0},
        {1'b0,1'b0,16'h0000,1'b0,3'd0,1'b0,1'b0,8'h00,16'h0002,5'd0}
    };

    function automatic string row_tag(input int i);
        case (i)
            0, 2, 20:             return "R2";
            1, 3, 6, 9, 12, 15:   return "R3";
            5, 11, 14:            return "R4";
            7, 8, 16, 17:         return "R5";
            4, 10, 13:            return "R6";
            default:              return "R7";
        endcase
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic drive(input logic st, input logic ca, input logic [15:0] tg,
                         input logic rt, input logic [2:0] cd, input logic c,
                         input logic s, input logic [7:0] a);
        step_req = st; call_req = ca; call_target = tg;
        ret_req = rt; ret_cond = cd; carry_in = c; sign_in = s; acc_in = a;
        @(negedge clk);
        step_req = 1'b0; call_req = 1'b0; ret_req = 1'b0;
        call_target = '0; ret_cond = '0; carry_in = 1'b0; sign_in = 1'b0; acc_in = '0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1: reset state
        check("R1", "ip", 32'(ip_out), 32'h0);
        check("R1", "depth", 32'(stack_depth), 32'd0);
        check("R1", "empty", 32'(stack_empty), 32'd1);
        check("R1", "full", 32'(stack_full), 32'd0);
        check("R1", "flags", {30'd0, overflow_flag, underflow_flag}, 32'd0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            logic [52:0] v;
            v = TBL[i];
            drive(v[52], v[51], v[50:35], v[34], v[33:31], v[30], v[29], v[28:21]);
            check(row_tag(i), "ip", 32'(ip_out), 32'(v[20:5]));
            check(row_tag(i), "depth", 32'(stack_depth), 32'(v[4:0]));
            check(row_tag(i), "flags", {30'd0, overflow_flag, underflow_flag}, 32'd0);
        end

        // R6: code 6 never taken, stack kept
        drive(1'b0, 1'b1, 16'h0700, 1'b0, 3'd0, 1'b0, 1'b0, 8'h00);
        drive(1'b0, 1'b0, 16'h0000, 1'b1, 3'd6, 1'b1, 1'b1, 8'h00);
        check("R7", "ip code6", 32'(ip_out), 32'h0701);
        check("R6", "depth code6", 32'(stack_depth), 32'd1);
        drive(1'b0, 1'b0, 16'h0000, 1'b1, 3'd7, 1'b0, 1'b0, 8'h00);
        check("R6", "entry kept", 32'(ip_out), 32'h0003);

        // R10: underflow
        do_reset();
        drive(1'b0, 1'b0, 16'h0000, 1'b1, 3'd7, 1'b0, 1'b0, 8'h00);
        check("R10", "ip", 32'(ip_out), 32'h0001);
        check("R10", "depth", 32'(stack_depth), 32'd0);
        check("R10", "unf flag", 32'(underflow_flag), 32'd1);
        drive(1'b0, 1'b0, 16'h0000, 1'b1, 3'd0, 1'b0, 1'b0, 8'h00);
        check("R10", "unf one cycle", 32'(underflow_flag), 32'd0);
        check("R6", "false on empty ip", 32'(ip_out), 32'h0002);

        // R8/R9: fill, overflow, drain
        do_reset();
        for (int k = 0; k < 16; k++) begin
            drive(1'b0, 1'b1, 16'h1000 + 16'(k), 1'b0, 3'd0, 1'b0, 1'b0, 8'h00);
            check("R8", "fill depth", 32'(stack_depth), 32'(k + 1));
        end
        check("R8", "full", 32'(stack_full), 32'd1);
        drive(1'b0, 1'b1, 16'h2000, 1'b0, 3'd0, 1'b0, 1'b0, 8'h00);
        check("R9", "ip", 32'(ip_out), 32'h1010);
        check("R9", "depth", 32'(stack_depth), 32'd16);
        check("R9", "ovf flag", 32'(overflow_flag), 32'd1);
        for (int k = 15; k >= 0; k--) begin
            drive(1'b0, 1'b0, 16'h0000, 1'b1, 3'd7, 1'b0, 1'b0, 8'h00);
            check("R8", "pop addr", 32'(ip_out), (k == 0) ? 32'h1 : 32'h1000 + 32'(k));
            if (k == 15) check("R9", "ovf one cycle", 32'(overflow_flag), 32'd0);
        end
        check("R8", "empty", 32'(stack_empty), 32'd1);

        // R11: call and return together
        do_reset();
        drive(1'b0, 1'b1, 16'h0050, 1'b0, 3'd0, 1'b0, 1'b0, 8'h00);
        drive(1'b0, 1'b1, 16'h0070, 1'b1, 3'd7, 1'b0, 1'b0, 8'h00);
        check("R11", "ip", 32'(ip_out), 32'h0070);
        check("R11", "depth", 32'(stack_depth), 32'd2);
        drive(1'b0, 1'b0, 16'h0000, 1'b1, 3'd7, 1'b0, 1'b0, 8'h00);
        check("R11", "pop1", 32'(ip_out), 32'h0051);
        drive(1'b0, 1'b0, 16'h0000, 1'b1, 3'd7, 1'b0, 1'b0, 8'h00);
        check("R11", "pop2", 32'(ip_out), 32'h0001);
        check("R11", "depth end", 32'(stack_depth), 32'd0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule